// File: doc/BRIEF.md
# Multiplexed-Bus Byte-Wide Channel Register Slave

This block lets a microcontroller-style external memory bus reach the parameter registers of a 32-channel tone generator. The host puts the low address byte on a shared 8-bit address/data bus and marks it with an address-latch pulse, then drives a high address byte on separate pins. It moves data one byte per cycle with active-low read and write strobes. The bus has no ready line, so read data has to be valid within a fixed window, and every write strobe has to land.

Each channel holds twelve parameter registers: a frequency word, an amplitude word, two filter coefficients, three sample-memory pointers and five further words. Even slots are 32 bits wide and odd slots are 24 bits wide. The latched address splits into a device select, a channel, a register slot and a byte lane. A mode pin sets how write strobes reach the core. In synchronized mode they pass through a two-stage synchronizer, which suits a host on an unrelated clock. In direct mode they are sampled once, for a host that shares the core clock.

Top module: `mxbus_regslave`

## Requirements
- R1: The latched address forms a 16-bit word {addr_hi, low byte}. Bits [15:11] must equal 5'b10110 to select the device. Bits [10:6] give the channel, bits [5:2] the register slot and bits [1:0] the byte lane, where lane 0 is the least significant byte. An access that does not select the device neither drives the bus nor changes any register.
- R2: The low address is taken from ad_in, and the high byte from addr_hi, at the first clock edge that samples ale low after ale was sampled high. Later changes on those pins while ale stays low have no effect.
- R3: Every byte of slots 0 to 11 in all 32 channels reads back the value last written to it. This holds in both strobe modes.
- R4: Slots 12 to 15 read as 0x00 and ignore writes.
- R5: Odd-numbered slots are 24 bits wide. Their byte lane 3 reads as 0x00 and ignores writes.
- R6: ad_oe is high only while rd_n is low and the latched address selects the device. Whenever ad_oe is low, ad_out is 0x00.
- R7: Each rising edge of wr_n commits ad_in to the addressed byte exactly once. Two strobes to the same byte, separated by three high cycles, both take effect.
- R8: With sync_en low, the write commits at the first clock edge that samples wr_n high.
- R9: With sync_en high, the write commits two clock edges later than in R8.
- R10: After reset, every register byte reads 0x00 and ad_oe is low.
- R11: Read data and ad_oe follow rd_n and the latched address combinationally, within the same cycle that rd_n falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_en | input | 1 | 1 = strobes pass through the synchronizer, 0 = direct sampling |
| ale | input | 1 | Address latch pulse; the low address is captured on its falling edge |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe; the write commits on its rising edge |
| addr_hi | input | 8 | High address byte |
| ad_in | input | 8 | Shared bus as seen from the pins: address, then write data |
| ad_out | output | 8 | Read data driven toward the shared bus |
| ad_oe | output | 1 | Output enable for ad_out |

## Verification
The assertions rely on three conditions on the inputs. Write data stays stable for three clock edges after wr_n rises. wr_n stays high for at least three cycles between strobes. sync_en changes only while wr_n is high and idle. The latency properties also require that the latched address still selects the device when the commit falls due.

The bench drives every pin on the falling clock edge. Its write task holds the data and the high strobe level for three further cycles. It switches modes only between bus cycles and never asserts the two strobes in a way that breaks these conditions. This keeps every check within the envelope that the properties assume.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

    localparam int LANES   = 4;
    localparam int LANE_W  = $clog2(LANES);
    localparam int DATA_W  = 8;

    // Odd slots hold 24-bit words; even slots hold full 32-bit words.
    function automatic logic slot_is_narrow(input logic [3:0] slot);
        return slot[0];
    endfunction

    // True when a slot/lane pair maps onto real storage.
    function automatic logic lane_exists(input logic [3:0] slot,
                                         input logic [LANE_W-1:0] lane,
                                         input int unsigned impl_slots);
        logic in_range;
        in_range = (32'(slot) < impl_slots);
        return in_range && !(slot_is_narrow(slot) && lane == LANE_W'(LANES - 1));
    endfunction

endpackage

// File: rtl/mxbus_addr_latch.sv
module mxbus_addr_latch #(
    parameter int HI_W = 8,
    parameter int LO_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ale,
    input  logic [HI_W-1:0]      addr_hi,
    input  logic [LO_W-1:0]      ad_in,
    output logic [HI_W+LO_W-1:0] lat_addr
);

    typedef struct packed {
        logic            ale_seen;
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.ale_seen = ale;
        if (st_q.ale_seen && !ale) begin
            st_d.lo = ad_in;
            st_d.hi = addr_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lat_addr = {st_q.hi, st_q.lo};

endmodule

// File: rtl/mxbus_strobe_cond.sv
module mxbus_strobe_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_en,
    input  logic strobe_n,
    output logic rise
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last_lvl;
    } cond_st_t;

    cond_st_t st_d, st_q;
    logic     level;

    always_comb begin
        level         = sync_en ? st_q.chain[STAGES-1] : strobe_n;
        st_d          = st_q;
        st_d.chain[0] = strobe_n;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.last_lvl = level;
    end

    // An idle strobe is high, so reset to the idle level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign rise = level && !st_q.last_lvl;

endmodule

// File: rtl/mxbus_chan_bank.sv
module mxbus_chan_bank
    import mxbus_pkg::*;
#(
    parameter int IMPL_SLOTS = 12,
    parameter int SLOT_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [SLOT_W-1:0]  slot,
    input  logic [LANE_W-1:0]  lane,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);

    localparam int DEPTH = IMPL_SLOTS * LANES;
    localparam int IDX_W = SLOT_W + LANE_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] cells;
    } bank_st_t;

    bank_st_t         st_d, st_q;
    logic             valid;
    logic [IDX_W-1:0] idx;

    always_comb begin
        valid = lane_exists(4'(slot), lane, IMPL_SLOTS);
        idx   = valid ? {slot, lane} : '0;
        st_d  = st_q;
        if (we && valid) st_d.cells[idx] = wdata;
        rdata = valid ? st_q.cells[idx] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/mxbus_regslave.sv
module mxbus_regslave
    import mxbus_pkg::*;
#(
    parameter int          NUM_CH      = 32,
    parameter int          IMPL_SLOTS  = 12,
    parameter int          SLOT_W      = 4,
    parameter int          HI_W        = 8,
    parameter int unsigned DEV_SEL     = 5'b10110,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_en,
    input  logic              ale,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [HI_W-1:0]   addr_hi,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe
);

    localparam int CH_W  = $clog2(NUM_CH);
    localparam int OFF_W = CH_W + SLOT_W + LANE_W;
    localparam int ADR_W = HI_W + DATA_W;
    localparam int SEL_W = ADR_W - OFF_W;

    logic [ADR_W-1:0]  lat_addr;
    logic [CH_W-1:0]   ch_idx;
    logic [SLOT_W-1:0] slot_idx;
    logic [LANE_W-1:0] byte_idx;
    logic              sel_hit;
    logic              wr_rise;
    logic              wr_commit;
    logic [DATA_W-1:0] bank_rd [NUM_CH];
    logic [DATA_W-1:0] rd_byte;

    mxbus_addr_latch #(.HI_W(HI_W), .LO_W(DATA_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ale      (ale),
        .addr_hi  (addr_hi),
        .ad_in    (ad_in),
        .lat_addr (lat_addr)
    );

    mxbus_strobe_cond #(.STAGES(SYNC_STAGES)) u_wr_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_en  (sync_en),
        .strobe_n (wr_n),
        .rise     (wr_rise)
    );

    always_comb begin
        ch_idx    = lat_addr[OFF_W-1 -: CH_W];
        slot_idx  = lat_addr[LANE_W +: SLOT_W];
        byte_idx  = lat_addr[LANE_W-1:0];
        sel_hit   = (lat_addr[ADR_W-1 -: SEL_W] == SEL_W'(DEV_SEL))
                    && (32'(ch_idx) < NUM_CH);
        wr_commit = wr_rise && sel_hit;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic bank_we;
        assign bank_we = wr_commit && (ch_idx == CH_W'(c));
        mxbus_chan_bank #(.IMPL_SLOTS(IMPL_SLOTS), .SLOT_W(SLOT_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we),
            .slot  (slot_idx),
            .lane  (byte_idx),
            .wdata (ad_in),
            .rdata (bank_rd[c])
        );
    end

    always_comb begin
        rd_byte = bank_rd[ch_idx];
        ad_oe   = !rd_n && sel_hit;
        ad_out  = ad_oe ? rd_byte : '0;
    end

endmodule

// File: rtl/mxbus_regslave_chk.sv
module mxbus_regslave_chk #(
    parameter int IMPL_SLOTS = 12,
    parameter int SLOT_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_en,
    input logic              rd_n,
    input logic              wr_n,
    input logic              ad_oe,
    input logic [7:0]        ad_out,
    input logic              sel_hit,
    input logic [SLOT_W-1:0] slot_idx,
    input logic [1:0]        byte_idx,
    input logic              wr_commit
);

    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    p_oe_needs_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |-> (!ad_oe && ad_out == 8'h00));

    p_oe_needs_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_hit |-> !ad_oe);

    p_hole_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && 32'(slot_idx) >= IMPL_SLOTS) |-> ad_out == 8'h00);

    p_narrow_top_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && slot_idx[0] && byte_idx == 2'd3) |-> ad_out == 8'h00);

    p_one_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

    p_direct_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && !sync_en && !$past(sync_en) && wr_n && !$past(wr_n)
         && sel_hit) |-> wr_commit);

    p_sync_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && sync_en && $past(sync_en) && $past(sync_en, 2)
         && $past(sync_en, 3) && $past(wr_n, 2) && !$past(wr_n, 3) && sel_hit)
        |-> wr_commit);

endmodule

bind mxbus_regslave mxbus_regslave_chk #(
    .IMPL_SLOTS (IMPL_SLOTS),
    .SLOT_W     (SLOT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_en   (sync_en),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ad_oe     (ad_oe),
    .ad_out    (ad_out),
    .sel_hit   (sel_hit),
    .slot_idx  (slot_idx),
    .byte_idx  (byte_idx),
    .wr_commit (wr_commit)
);

// File: tb/mxbus_regslave_tb_top.sv
module mxbus_regslave_tb_top;

    localparam logic [4:0] DEV = 5'b10110;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_en = 1'b0;
    logic       ale = 1'b0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] addr_hi = '0;
    logic [7:0] ad_in = '0;
    logic [7:0] ad_out;
    logic       ad_oe;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] model [32][16][4];

    always #5 clk = ~clk;

    mxbus_regslave dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_en (sync_en),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .addr_hi (addr_hi),
        .ad_in   (ad_in),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic writable(input int slot, input int b);
        return (slot < 12) && !((slot % 2 == 1) && b == 3);
    endfunction

    function automatic logic [7:0] pattern(input int ch, input int slot, input int b, input int seed);
        return 8'((ch * 29 + slot * 11 + b * 71 + seed * 53) ^ (ch << 3));
    endfunction

    task automatic bus_addr(input logic [4:0] dev, input int ch, input int slot, input int b);
        logic [15:0] a;
        a = {dev, 5'(ch), 4'(slot), 2'(b)};
        @(negedge clk);
        ale = 1'b1; addr_hi = a[15:8]; ad_in = a[7:0];
        @(negedge clk);
        ale = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [4:0] dev, input int ch, input int slot, input int b,
                             input logic [7:0] d);
        bus_addr(dev, ch, slot, b);
        ad_in = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        if (dev == DEV && writable(slot, b)) model[ch][slot][b] = d;
    endtask

    task automatic bus_read(input logic [4:0] dev, input int ch, input int slot, input int b,
                            output logic [7:0] d, output logic oe);
        bus_addr(dev, ch, slot, b);
        rd_n = 1'b0;
        #2;
        d = ad_out; oe = ad_oe;
        @(negedge clk);
        rd_n = 1'b1;
    endtask

    task automatic t_reset_state;
        logic [7:0] d; logic oe;
        #2;
        chk("R10 oe after reset", 8'(ad_oe), 8'h00);
        bus_read(DEV, 0, 0, 0, d, oe);  chk("R10 ch0 byte", d, 8'h00);
        bus_read(DEV, 31, 10, 3, d, oe); chk("R10 ch31 top byte", d, 8'h00);
        chk("R6 oe on selected read", 8'(oe), 8'h01);
    endtask

    task automatic t_fill(input logic mode, input int seed);
        sync_en = mode;
        for (int ch = 0; ch < 32; ch++)
            for (int s = 0; s < 16; s++)
                for (int b = 0; b < 4; b++)
                    bus_write(DEV, ch, s, b, pattern(ch, s, b, seed));
    endtask

    task automatic t_readback(input logic mode);
        logic [7:0] d; logic oe;
        sync_en = mode;
        for (int ch = 0; ch < 32; ch++)
            for (int s = 0; s < 16; s++)
                for (int b = 0; b < 4; b++) begin
                    bus_read(DEV, ch, s, b, d, oe);
                    if (s >= 12)       chk("R4 unused slot", d, 8'h00);
                    else if (!writable(s, b)) chk("R5 24-bit top lane", d, 8'h00);
                    else               chk("R3 readback", d, model[ch][s][b]);
                end
    endtask

    task automatic t_latency(input logic mode);
        logic [7:0] old_v, new_v;
        sync_en = mode;
        old_v = model[5][2][1];
        new_v = ~old_v;
        bus_addr(DEV, 5, 2, 1);
        ad_in = new_v; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b0;
        #2;
        chk(mode ? "R9 before commit" : "R8 before commit", ad_out, old_v);
        if (!mode) begin
            @(negedge clk); #2; chk("R8 first edge", ad_out, new_v);
        end else begin
            @(negedge clk); #2; chk("R9 one edge", ad_out, old_v);
            @(negedge clk); #2; chk("R9 two edges", ad_out, old_v);
            @(negedge clk); #2; chk("R9 third edge", ad_out, new_v);
        end
        @(negedge clk);
        rd_n = 1'b1;
        model[5][2][1] = new_v;
    endtask

    task automatic t_back_to_back(input logic mode);
        sync_en = mode;
        bus_addr(DEV, 9, 4, 0);
        rd_n = 1'b0;
        ad_in = 8'h3C; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        repeat (3) @(negedge clk);
        #2; chk("R7 first strobe", ad_out, 8'h3C);
        ad_in = 8'hC3; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        repeat (3) @(negedge clk);
        #2; chk("R7 second strobe", ad_out, 8'hC3);
        @(negedge clk); rd_n = 1'b1;
        model[9][4][0] = 8'hC3;
    endtask

    task automatic t_unselected;
        logic [7:0] d; logic oe;
        bus_read(5'b00110, 3, 0, 0, d, oe);
        chk("R1 foreign oe", 8'(oe), 8'h00);
        chk("R6 foreign data", d, 8'h00);
        bus_write(5'b10111, 3, 0, 0, ~model[3][0][0]);
        bus_read(DEV, 3, 0, 0, d, oe);
        chk("R1 foreign write ignored", d, model[3][0][0]);
    endtask

    task automatic t_rd_release;
        bus_addr(DEV, 7, 6, 2);
        #2;
        chk("R6 idle oe", 8'(ad_oe), 8'h00);
        chk("R6 idle data", ad_out, 8'h00);
        @(negedge clk);
        rd_n = 1'b0;
        #1;
        chk("R11 same-cycle oe", 8'(ad_oe), 8'h01);
        chk("R11 same-cycle data", ad_out, model[7][6][2]);
        @(negedge clk);
        rd_n = 1'b1;
    endtask

    task automatic t_ale_hold;
        bus_addr(DEV, 12 + 0, 8, 3);
        ad_in = 8'hFF; addr_hi = 8'h00;
        @(negedge clk);
        rd_n = 1'b0;
        #2;
        chk("R2 latched oe", 8'(ad_oe), 8'h01);
        chk("R2 latched data", ad_out, model[12][8][3]);
        @(negedge clk);
        rd_n = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int ch = 0; ch < 32; ch++)
            for (int s = 0; s < 16; s++)
                for (int b = 0; b < 4; b++)
                    model[ch][s][b] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_fill(1'b0, 1);
        t_readback(1'b0);
        t_latency(1'b0);
        t_back_to_back(1'b0);
        t_fill(1'b1, 2);
        t_readback(1'b1);
        t_latency(1'b1);
        t_back_to_back(1'b1);
        t_unselected();
        t_rd_release();
        t_ale_hold();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule